// File: doc/BRIEF.md
# Serial Target Port with Pause Control

This block is the bit-level front end of a serial target device on a four-wire synchronous bus. It supports clock polarity/phase modes 0 and 3. A transaction is framed by an active-low select line, and data moves most-significant bit first. Each complete received word goes to a command engine together with a one-cycle valid strobe. The port also gives one-cycle strobes when a frame opens and when it closes. In the other direction, the engine supplies the next word to send, and the port pulses `tx_load` in the cycle it takes that word. Commands are not decoded here.

All serial inputs are assumed to be synchronised to the fast system clock already. The port finds edges by comparing each input with its value in the previous cycle.

A pause input lets the bus master freeze a transfer part-way through:
- While paused, the output driver is off and serial clock edges are ignored.
- The bit position is kept, so the transfer continues where it stopped once the pause is released.
- The pause only starts or ends while the serial clock is low.

Top module: `spi_target_port`

## Requirements
- R1: While reset is held and in the cycles after it, before any select, `ser_out_en`, `rx_valid`, `tx_load`, `frame_start` and `frame_end` are all 0.
- R2: `ser_out_en` is 0 in every cycle that follows a cycle with `sel_n` high. It is also 0 while a pause is in effect.
- R3: One system cycle after `sel_n` falls, `frame_start` pulses for exactly one cycle. One cycle after `sel_n` rises, `frame_end` pulses for exactly one cycle.
- R4: `ser_in` is sampled on rising `ser_clk` edges, most-significant bit first. One cycle after the WORD-th rising edge, `rx_valid` pulses for one cycle with the assembled word on `rx_word`. This holds in both mode 0 (clock idles low) and mode 3 (clock idles high).
- R5: The bit position returns to the top bit at every select fall. A partial word left over from an earlier frame has no effect on the next word received.
- R6: At a select fall, `tx_word` is loaded and `tx_load` pulses, so `ser_out` carries the top bit before the first rising edge. Each falling edge that follows a rising edge moves to the next bit. In mode 3, the leading falling edge, which has no rising edge before it, does not advance the output.
- R7: The falling edge that follows the last bit of a word loads the next `tx_word` and pulses `tx_load`, so words sent back to back have no gap.
- R8: Pulling `pause_n` low while `ser_clk` is low turns `ser_out_en` off. While paused, rising edges on `ser_clk` are neither sampled nor counted. Raising `pause_n` while `ser_clk` is low resumes the transfer at the bit where it stopped, for both received and sent data.
- R9: If `pause_n` goes low while `ser_clk` is high, the pause waits until `ser_clk` is next low. `ser_out_en` stays 1 until then.
- R10: A `sel_n` rise during a pause ends the frame, clears the pause and throws away the partial received word, so no `rx_valid` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial bus clock (synchronised) |
| sel_n | input | 1 | Active-low frame select |
| ser_in | input | 1 | Serial data from master |
| pause_n | input | 1 | Active-low pause request |
| tx_word | input | WORD | Next word to transmit |
| tx_load | output | 1 | Pulses when `tx_word` is taken |
| rx_word | output | WORD | Last complete received word |
| rx_valid | output | 1 | One-cycle strobe for `rx_word` |
| frame_start | output | 1 | One-cycle strobe after select falls |
| frame_end | output | 1 | One-cycle strobe after select rises |
| ser_out | output | 1 | Serial data to master |
| ser_out_en | output | 1 | Output driver enable |

## Verification
Two-word frames are run in mode 0 and in mode 3. Comparing them shows whether the leading idle-high falling edge is wrongly treated as a shift, and whether the next transmit word is loaded with no gap. A frame is abandoned after three bits and followed by a clean word, which shows whether the bit position really resets at each select. A pause taken mid-word, with noisy clock and data toggled during it, shows whether held edges leak into the shift registers. A pause requested while the clock is high shows whether the request is deferred. Finally, deselecting while paused shows whether the pause state and the partial word are dropped.

// File: rtl/spi_target_port.sv
module spi_target_port #(
  parameter int WORD = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ser_clk,
  input  logic            sel_n,
  input  logic            ser_in,
  input  logic            pause_n,
  input  logic [WORD-1:0] tx_word,
  output logic            tx_load,
  output logic [WORD-1:0] rx_word,
  output logic            rx_valid,
  output logic            frame_start,
  output logic            frame_end,
  output logic            ser_out,
  output logic            ser_out_en
);
  localparam int CW = $clog2(WORD);
  localparam logic [CW-1:0] LAST = CW'(WORD - 1);

  logic            clk_q, sel_q, held, rise_seen;
  logic [CW-1:0]   bit_cnt;
  logic [WORD-2:0] rx_sh;
  logic [WORD-1:0] tx_sh;

  wire clk_rise = ser_clk & ~clk_q;
  wire clk_fall = ~ser_clk & clk_q;
  wire sel_fall = ~sel_n & sel_q;
  wire sel_rise = sel_n & ~sel_q;
  wire live     = ~sel_n & ~sel_q & ~held;
  wire wrap     = (bit_cnt == LAST);

  assign ser_out    = tx_sh[WORD-1];
  assign ser_out_en = ~sel_q & ~held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_q       <= 1'b0;
      sel_q       <= 1'b1;
      held        <= 1'b0;
      rise_seen   <= 1'b0;
      bit_cnt     <= '0;
      rx_sh       <= '0;
      tx_sh       <= '0;
      rx_word     <= '0;
      rx_valid    <= 1'b0;
      tx_load     <= 1'b0;
      frame_start <= 1'b0;
      frame_end   <= 1'b0;
    end else begin
      clk_q       <= ser_clk;
      sel_q       <= sel_n;
      frame_start <= sel_fall;
      frame_end   <= sel_rise;
      rx_valid    <= 1'b0;
      tx_load     <= 1'b0;

      if (sel_n)         held <= 1'b0;
      else if (!ser_clk) held <= ~pause_n;

      if (sel_n) begin
        bit_cnt   <= '0;
        rise_seen <= 1'b0;
      end else if (sel_fall) begin
        bit_cnt   <= '0;
        rise_seen <= 1'b0;
        tx_sh     <= tx_word;
        tx_load   <= 1'b1;
      end else if (live) begin
        if (clk_rise) begin
          rx_sh     <= {rx_sh[WORD-3:0], ser_in};
          rise_seen <= 1'b1;
          bit_cnt   <= wrap ? '0 : bit_cnt + 1'b1;
          if (wrap) begin
            rx_word  <= {rx_sh, ser_in};
            rx_valid <= 1'b1;
          end
        end
        if (clk_fall && rise_seen) begin
          rise_seen <= 1'b0;
          if (bit_cnt == '0) begin
            tx_sh   <= tx_word;
            tx_load <= 1'b1;
          end else begin
            tx_sh <= {tx_sh[WORD-2:0], 1'b0};
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_target_port_chk.sv
module spi_target_port_chk (
  input logic clk,
  input logic rst_n,
  input logic ser_clk,
  input logic sel_n,
  input logic rx_valid,
  input logic tx_load,
  input logic frame_start,
  input logic frame_end,
  input logic ser_out_en
);
  // R2
  oe_desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sel_n) |-> !ser_out_en);
  // R3
  start_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sel_n) |=> frame_start);
  // R3
  end_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_n) |=> frame_end);
  // R4
  rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  // R10
  rx_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !$past(sel_n));
  // R7
  tx_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |-> !$past(sel_n));
  // R9
  pause_defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ser_clk) && $past(ser_out_en) && !$past(sel_n)) |-> ser_out_en);
endmodule

bind spi_target_port spi_target_port_chk chk_i (.*);

// File: tb/spi_target_port_tb_top.sv
module spi_target_port_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, sel_n = 1'b1, ser_in = 1'b0, pause_n = 1'b1;
  logic [7:0] tx_word, rx_word;
  logic tx_load, rx_valid, frame_start, frame_end, ser_out, ser_out_en;

  int checks = 0, fails = 0;
  int rx_cnt = 0, ld_cnt = 0, fs_cnt = 0, fe_cnt = 0;
  logic [7:0] last_rx = '0;
  logic [7:0] hist [64];

  always #10 clk = ~clk;

  assign tx_word = 8'h96 ^ 8'(ld_cnt * 29);

  spi_target_port #(.WORD(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .sel_n(sel_n), .ser_in(ser_in),
    .pause_n(pause_n), .tx_word(tx_word), .tx_load(tx_load), .rx_word(rx_word),
    .rx_valid(rx_valid), .frame_start(frame_start), .frame_end(frame_end),
    .ser_out(ser_out), .ser_out_en(ser_out_en));

  always @(posedge clk) begin
    #1;
    if (rx_valid) begin last_rx = rx_word; rx_cnt++; end
    if (tx_load) begin hist[ld_cnt % 64] = tx_word; ld_cnt++; end
    if (frame_start) fs_cnt++;
    if (frame_end) fe_cnt++;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step2();
    @(negedge clk); @(negedge clk);
  endtask

  task automatic bit_m0(input logic b, output logic s);
    ser_in = b; s = ser_out;
    ser_clk = 1'b1; step2();
    ser_clk = 1'b0; step2();
  endtask

  task automatic bit_m3(input logic b, output logic s);
    ser_clk = 1'b0; step2();
    ser_in = b; s = ser_out;
    ser_clk = 1'b1; step2();
  endtask

  task automatic word_xfer(input bit m3, input logic [7:0] mosi,
                           output logic [7:0] miso, output logic [7:0] exp_tx);
    logic s;
    exp_tx = '0;
    for (int i = 7; i >= 0; i--) begin
      if (m3) bit_m3(mosi[i], s); else bit_m0(mosi[i], s);
      miso[i] = s;
      if (i == 7) exp_tx = hist[(ld_cnt - 1) % 64];
    end
  endtask

  task automatic select_frame();
    int f0 = fs_cnt;
    sel_n = 1'b0; step2();
    chk("R3 frame_start count", fs_cnt - f0, 1);
  endtask

  task automatic deselect_frame();
    int e0 = fe_cnt;
    sel_n = 1'b1; step2();
    chk("R3 frame_end count", fe_cnt - e0, 1);
    chk("R2 oe off when deselected", ser_out_en, 0);
  endtask

  task automatic t_reset();
    chk("R1 oe", ser_out_en, 0);
    chk("R1 rx_valid", rx_valid, 0);
    chk("R1 strobes", {tx_load, frame_start, frame_end}, 0);
    chk("R1 no rx", rx_cnt, 0);
  endtask

  task automatic t_two_words(input bit m3, input logic [7:0] a, input logic [7:0] b);
    logic [7:0] mi, ex;
    int r0, l0;
    ser_clk = m3; step2();
    l0 = ld_cnt;
    select_frame();
    chk("R2 oe on when selected", ser_out_en, 1);
    r0 = rx_cnt;
    word_xfer(m3, a, mi, ex);
    chk("R4 first word rx", last_rx, a);
    chk("R6 first word tx", mi, ex);
    word_xfer(m3, b, mi, ex);
    chk("R4 second word rx", last_rx, b);
    chk("R7 second word tx gapless", mi, ex);
    chk("R4 rx count", rx_cnt - r0, 2);
    chk("R7 tx_load count", ld_cnt - l0, m3 ? 2 : 3);
    deselect_frame();
  endtask

  task automatic t_partial_reset();
    logic s;
    logic [7:0] mi, ex;
    int r0;
    ser_clk = 1'b0; step2();
    select_frame();
    r0 = rx_cnt;
    bit_m0(1'b1, s); bit_m0(1'b1, s); bit_m0(1'b1, s);
    deselect_frame();
    select_frame();
    word_xfer(1'b0, 8'h3C, mi, ex);
    chk("R5 word after partial", last_rx, 8'h3C);
    chk("R5 exactly one word", rx_cnt - r0, 1);
    deselect_frame();
  endtask

  task automatic t_pause_mid();
    logic s;
    logic [7:0] mi, ex, mo;
    int r0;
    mo = 8'hB3;
    ser_clk = 1'b0; step2();
    select_frame();
    r0 = rx_cnt;
    ex = hist[(ld_cnt - 1) % 64];
    for (int i = 7; i >= 4; i--) begin bit_m0(mo[i], s); mi[i] = s; end
    pause_n = 1'b0; step2();
    chk("R8 oe off while paused", ser_out_en, 0);
    for (int k = 0; k < 3; k++) begin
      ser_in = k[0]; ser_clk = 1'b1; step2(); ser_clk = 1'b0; step2();
    end
    chk("R8 no word during pause", rx_cnt - r0, 0);
    pause_n = 1'b1; step2();
    chk("R8 oe back after resume", ser_out_en, 1);
    for (int i = 3; i >= 0; i--) begin bit_m0(mo[i], s); mi[i] = s; end
    chk("R8 rx continues", last_rx, mo);
    chk("R8 tx continues", mi, ex);
    deselect_frame();
  endtask

  task automatic t_pause_defer();
    logic s;
    logic [7:0] mo;
    mo = 8'h6E;
    ser_clk = 1'b0; step2();
    select_frame();
    bit_m0(mo[7], s); bit_m0(mo[6], s);
    ser_in = mo[5]; ser_clk = 1'b1; step2();
    pause_n = 1'b0; step2();
    chk("R9 oe held while clk high", ser_out_en, 1);
    ser_clk = 1'b0; step2();
    chk("R9 pause after clk low", ser_out_en, 0);
    pause_n = 1'b1; step2();
    for (int i = 4; i >= 0; i--) bit_m0(mo[i], s);
    chk("R9 word intact", last_rx, mo);
    deselect_frame();
  endtask

  task automatic t_desel_paused();
    logic s;
    logic [7:0] mi, ex;
    int r0;
    ser_clk = 1'b0; step2();
    select_frame();
    r0 = rx_cnt;
    bit_m0(1'b0, s); bit_m0(1'b1, s); bit_m0(1'b0, s);
    pause_n = 1'b0; step2();
    deselect_frame();
    pause_n = 1'b1; step2();
    chk("R10 partial discarded", rx_cnt - r0, 0);
    select_frame();
    chk("R10 pause cleared", ser_out_en, 1);
    word_xfer(1'b0, 8'hC5, mi, ex);
    chk("R10 clean word", last_rx, 8'hC5);
    deselect_frame();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    step2();
    t_reset();
    t_two_words(1'b0, 8'hA7, 8'h19);
    t_two_words(1'b1, 8'h4D, 8'hF0);
    t_partial_reset();
    t_pause_mid();
    t_pause_defer();
    t_desel_paused();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule